// File: doc/BRIEF.md
# Bank Address Generator for a CPU Interposer

This block is glue logic for a programmable-logic device on an interposer board. A 65xx-family CPU with 16-bit extensions sits on the board in place of an older CPU that had its bank registers on chip. The block drives the 4-bit high-address bus to the motherboard, which selects one of sixteen 64K banks. It also routes the 8-bit data bus between the CPU and the motherboard.

The CPU's emulation-mode pin picks where the bank bits come from. When the pin is high, the block behaves like the legacy part. Two emulated bank registers sit at addresses $0000 and $0001: an execution register and an indirect register. The block drives the execution register on the bank bus, except during phase 2 of a cycle that the sideband input flags as an indirect-bank access, when it drives the indirect register. When the pin is low, both registers are hidden. The bank bits then come from a latch. The latch is transparent while phase 1 is high, because that is when the CPU puts its bank byte on the data pins. It holds from the fall of phase 1 through phase 2.

All logic is clocked from a fast board clock, and the phase signals are sampled as levels. The block comes out of reset as the legacy CPU, with both registers at bank 15.

Top module: `bank_addr_gen`

## Requirements
- R1: In emulation mode (`emu_i`=1), `bank_o` equals the execution register unless `ind_cyc_i` and `phi2_i` are both 1. During phase 1, `ind_cyc_i` has no effect.
- R2: In emulation mode, when `ind_cyc_i`=1 and `phi2_i`=1, `bank_o` equals the indirect register.
- R3: In native mode (`emu_i`=0), while `phi1_i`=1, `bank_o` follows `cpu_data_i[3:0]` in the same cycle. Bits 7:4 of `cpu_data_i` are ignored.
- R4: In native mode, after `phi1_i` falls, `bank_o` holds the last value seen in phase 1. It does not change while `phi1_i` stays low, whatever `cpu_data_i` does.
- R5: In emulation mode, a phase-2 write (`rw_i`=0) to $0000 loads `cpu_data_i[3:0]` into the execution register, and one to $0001 loads the indirect register. The new value appears on `bank_o` one clock later. The write is also passed to the motherboard.
- R6: In native mode, accesses to $0000 and $0001 reach the motherboard: reads return `mb_data_i` to the CPU, and writes leave both bank registers unchanged.
- R7: In emulation mode, a phase-2 read (`rw_i`=1) of $0000 or $0001 drives `cpu_data_o` = {4'h0, register} with `cpu_data_oe_o`=1. `mb_data_oe_o` stays 0.
- R8: On any other phase-2 read, `cpu_data_oe_o`=1 and `cpu_data_o`=`mb_data_i`. On a phase-2 write, `mb_data_oe_o`=1 and `mb_data_o`=`cpu_data_i`. When `phi2_i`=0, both enables are 0, and the two enables are never 1 together.
- R9: While `rst_ni`=0, both registers and the bank latch are 4'hF, so `bank_o`=4'hF in emulation mode, and the block starts up as the legacy CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Board clock, faster than the CPU phases |
| rst_ni | input | 1 | Asynchronous reset, active low |
| emu_i | input | 1 | CPU emulation-mode pin, 1 = emulation |
| phi1_i | input | 1 | CPU clock phase 1 level |
| phi2_i | input | 1 | CPU clock phase 2 level |
| rw_i | input | 1 | CPU read/write, 1 = read |
| addr_i | input | 16 | CPU address bus |
| ind_cyc_i | input | 1 | Sideband flag for an indirect-bank cycle |
| cpu_data_i | input | 8 | Data driven by the CPU |
| mb_data_i | input | 8 | Data driven by the motherboard |
| cpu_data_o | output | 8 | Data to the CPU |
| cpu_data_oe_o | output | 1 | Enable for driving the CPU data bus |
| mb_data_o | output | 8 | Data to the motherboard |
| mb_data_oe_o | output | 1 | Enable for driving the motherboard data bus |
| bank_o | output | 4 | High address bits to the motherboard |

## Verification
Some properties are checked on every cycle:
- the two data enables are never on together, and both are off outside phase 2;
- the bank bus follows the data pins during native phase 1 and stays stable while the latch is closed;
- an emulation-mode write to the execution register appears on the bank bus one clock later;
- native reads always pass the motherboard data through.

Other behaviours need the bench's scenarios because they depend on history across mode changes:
- a native-mode write to $0000 leaves the execution register untouched, which is seen once the CPU is back in emulation mode;
- the indirect register reaches the bus only in phase 2 of a flagged cycle;
- reset restores bank 15.

// File: rtl/bank_pkg.sv
package bank_pkg;
  typedef enum logic [1:0] {
    SRC_EXEC  = 2'd0,
    SRC_IND   = 2'd1,
    SRC_LATCH = 2'd2
  } bank_src_e;
endpackage

// File: rtl/bank_latch.sv
// Flop plus bypass: open_i high passes d_i through and captures it each clock.
module bank_latch #(
  parameter int              W       = 4,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= RST_VAL;
    else if (open_i) hold_q <= d_i;
  end

  assign q_o = open_i ? d_i : hold_q;
endmodule

// File: rtl/bank_regs.sv
module bank_regs #(
  parameter int           W       = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_exec_i,
  input  logic         wr_ind_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] exec_o,
  output logic [W-1:0] ind_o
);
  logic [W-1:0] exec_q, ind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_q <= RST_VAL;
      ind_q  <= RST_VAL;
    end else begin
      if (wr_exec_i) exec_q <= wdata_i;
      if (wr_ind_i)  ind_q  <= wdata_i;
    end
  end

  assign exec_o = exec_q;
  assign ind_o  = ind_q;
endmodule

// File: rtl/bus_router.sv
module bus_router #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 4
) (
  input  logic              phi2_i,
  input  logic              rw_i,
  input  logic              reg_hit_i,
  input  logic [BANK_W-1:0] reg_val_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic [DATA_W-1:0] mb_data_i,
  output logic [DATA_W-1:0] cpu_data_o,
  output logic              cpu_data_oe_o,
  output logic [DATA_W-1:0] mb_data_o,
  output logic              mb_data_oe_o
);
  localparam int PAD_W = DATA_W - BANK_W;

  logic [DATA_W-1:0] reg_word;
  assign reg_word = {{PAD_W{1'b0}}, reg_val_i};

  always_comb begin
    cpu_data_oe_o = phi2_i && rw_i;
    mb_data_oe_o  = phi2_i && !rw_i;
    // register reads shadow the motherboard to avoid contention
    cpu_data_o    = reg_hit_i ? reg_word : mb_data_i;
    mb_data_o     = cpu_data_i;
  end
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
  import bank_pkg::*;
#(
  parameter int                BANK_W     = 4,
  parameter int                DATA_W     = 8,
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] EXEC_ADDR  = 16'h0000,
  parameter logic [ADDR_W-1:0] IND_ADDR   = 16'h0001,
  parameter logic [BANK_W-1:0] RESET_BANK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              emu_i,
  input  logic              phi1_i,
  input  logic              phi2_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ind_cyc_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic [DATA_W-1:0] mb_data_i,
  output logic [DATA_W-1:0] cpu_data_o,
  output logic              cpu_data_oe_o,
  output logic [DATA_W-1:0] mb_data_o,
  output logic              mb_data_oe_o,
  output logic [BANK_W-1:0] bank_o
);
  logic              hit_exec, hit_ind, wr_stb;
  logic [BANK_W-1:0] exec_val, ind_val, latch_val, reg_val;
  bank_src_e         src;

  assign hit_exec = emu_i && (addr_i == EXEC_ADDR);
  assign hit_ind  = emu_i && (addr_i == IND_ADDR);
  assign wr_stb   = phi2_i && !rw_i;
  assign reg_val  = hit_ind ? ind_val : exec_val;

  bank_regs #(.W(BANK_W), .RST_VAL(RESET_BANK)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_exec_i (wr_stb && hit_exec),
    .wr_ind_i  (wr_stb && hit_ind),
    .wdata_i   (cpu_data_i[BANK_W-1:0]),
    .exec_o    (exec_val),
    .ind_o     (ind_val)
  );

  bank_latch #(.W(BANK_W), .RST_VAL(RESET_BANK)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (phi1_i),
    .d_i    (cpu_data_i[BANK_W-1:0]),
    .q_o    (latch_val)
  );

  bus_router #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_router (
    .phi2_i        (phi2_i),
    .rw_i          (rw_i),
    .reg_hit_i     (hit_exec || hit_ind),
    .reg_val_i     (reg_val),
    .cpu_data_i    (cpu_data_i),
    .mb_data_i     (mb_data_i),
    .cpu_data_o    (cpu_data_o),
    .cpu_data_oe_o (cpu_data_oe_o),
    .mb_data_o     (mb_data_o),
    .mb_data_oe_o  (mb_data_oe_o)
  );

  always_comb begin
    if (!emu_i)                   src = SRC_LATCH;
    else if (ind_cyc_i && phi2_i) src = SRC_IND;
    else                          src = SRC_EXEC;
  end

  always_comb begin
    unique case (src)
      SRC_IND:   bank_o = ind_val;
      SRC_LATCH: bank_o = latch_val;
      default:   bank_o = exec_val;
    endcase
  end
endmodule

// File: rtl/bank_addr_gen_chk.sv
module bank_addr_gen_chk #(
  parameter int                BANK_W    = 4,
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] EXEC_ADDR = 16'h0000,
  parameter logic [ADDR_W-1:0] IND_ADDR  = 16'h0001
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              emu_i,
  input logic              phi1_i,
  input logic              phi2_i,
  input logic              rw_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ind_cyc_i,
  input logic [DATA_W-1:0] cpu_data_i,
  input logic [DATA_W-1:0] mb_data_i,
  input logic [DATA_W-1:0] cpu_data_o,
  input logic              cpu_data_oe_o,
  input logic              mb_data_oe_o,
  input logic [BANK_W-1:0] bank_o
);
  localparam int PAD_W = DATA_W - BANK_W;

  logic reg_addr;
  assign reg_addr = (addr_i == EXEC_ADDR) || (addr_i == IND_ADDR);

  assert_oe_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_data_oe_o && mb_data_oe_o));

  assert_oe_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phi2_i |-> !cpu_data_oe_o && !mb_data_oe_o);

  assert_latch_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!emu_i && phi1_i) |-> bank_o == cpu_data_i[BANK_W-1:0]);

  assert_latch_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!emu_i && !phi1_i && $past(!emu_i) && $past(!phi1_i)) |-> $stable(bank_o));

  assert_exec_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emu_i && phi2_i && !rw_i && addr_i == EXEC_ADDR)
      ##1 (emu_i && !(ind_cyc_i && phi2_i)) |-> bank_o == $past(cpu_data_i[BANK_W-1:0]));

  assert_native_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!emu_i && phi2_i && rw_i) |-> cpu_data_oe_o && cpu_data_o == mb_data_i);

  assert_reg_read_pad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emu_i && phi2_i && rw_i && reg_addr) |->
      cpu_data_oe_o && !mb_data_oe_o && cpu_data_o[DATA_W-1:BANK_W] == {PAD_W{1'b0}});
endmodule

bind bank_addr_gen bank_addr_gen_chk #(
  .BANK_W(BANK_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .EXEC_ADDR(EXEC_ADDR), .IND_ADDR(IND_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .emu_i(emu_i), .phi1_i(phi1_i),
  .phi2_i(phi2_i), .rw_i(rw_i), .addr_i(addr_i), .ind_cyc_i(ind_cyc_i),
  .cpu_data_i(cpu_data_i), .mb_data_i(mb_data_i), .cpu_data_o(cpu_data_o),
  .cpu_data_oe_o(cpu_data_oe_o), .mb_data_oe_o(mb_data_oe_o), .bank_o(bank_o)
);

// File: tb/bank_addr_gen_tb.sv
module bank_addr_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic        emu, phi1, phi2, rw;
    logic [15:0] addr;
    logic        ind;
    logic [7:0]  cpu_d, mb_d;
    logic [3:0]  exp_bank;
    logic        exp_coe, exp_moe;
    logic [7:0]  exp_data;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b0,1'b1,1'b1,16'h1234,1'b0,8'h00,8'hA5,4'hF,1'b1,1'b0,8'hA5},
    '{1'b1,1'b0,1'b1,1'b0,16'h0000,1'b0,8'h03,8'h00,4'h3,1'b0,1'b1,8'h03},
    '{1'b1,1'b0,1'b1,1'b0,16'h0001,1'b0,8'h07,8'h00,4'h3,1'b0,1'b1,8'h07},
    '{1'b1,1'b0,1'b1,1'b1,16'h0001,1'b1,8'h00,8'hEE,4'h7,1'b1,1'b0,8'h07},
    '{1'b1,1'b0,1'b1,1'b1,16'h0000,1'b0,8'h00,8'hEE,4'h3,1'b1,1'b0,8'h03},
    '{1'b1,1'b1,1'b0,1'b1,16'h0000,1'b1,8'h00,8'hEE,4'h3,1'b0,1'b0,8'h00},
    '{1'b0,1'b1,1'b0,1'b1,16'h2000,1'b0,8'h0C,8'h00,4'hC,1'b0,1'b0,8'h00},
    '{1'b0,1'b0,1'b1,1'b1,16'h0000,1'b0,8'h05,8'h5A,4'hC,1'b1,1'b0,8'h5A},
    '{1'b0,1'b0,1'b1,1'b0,16'h0000,1'b0,8'h09,8'h00,4'hC,1'b0,1'b1,8'h09},
    '{1'b1,1'b0,1'b1,1'b1,16'h0000,1'b0,8'h00,8'h11,4'h3,1'b1,1'b0,8'h03},
    '{1'b0,1'b1,1'b0,1'b1,16'h3000,1'b0,8'hF2,8'h00,4'h2,1'b0,1'b0,8'h00},
    '{1'b0,1'b0,1'b0,1'b1,16'h3000,1'b0,8'h6D,8'h00,4'h2,1'b0,1'b0,8'h00},
    '{1'b0,1'b0,1'b1,1'b1,16'h0100,1'b1,8'h0B,8'h42,4'h2,1'b1,1'b0,8'h42},
    '{1'b1,1'b0,1'b0,1'b0,16'h0000,1'b0,8'h0A,8'h00,4'h3,1'b0,1'b0,8'h00}
  };

  function automatic string tag(int i);
    case (i)
      0:  return "R8 plain read";
      1:  return "R5 exec write";
      2:  return "R5 ind write";
      3:  return "R2/R7 ind read";
      4:  return "R1/R7 exec read";
      5:  return "R1 ind in phase1";
      6:  return "R3 latch open";
      7:  return "R4/R6 native read $0000";
      8:  return "R6 native write $0000";
      9:  return "R6 exec unchanged";
      10: return "R3 upper bits ignored";
      11: return "R4 hold idle";
      12: return "R4 native ind flag";
      default: return "R8 idle no write";
    endcase
  endfunction

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        emu_i = 1'b1, phi1_i = 1'b0, phi2_i = 1'b0, rw_i = 1'b1, ind_cyc_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  cpu_data_i = '0, mb_data_i = '0;
  logic [7:0]  cpu_data_o, mb_data_o;
  logic        cpu_data_oe_o, mb_data_oe_o;
  logic [3:0]  bank_o;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bank_addr_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .emu_i(emu_i), .phi1_i(phi1_i), .phi2_i(phi2_i),
    .rw_i(rw_i), .addr_i(addr_i), .ind_cyc_i(ind_cyc_i), .cpu_data_i(cpu_data_i),
    .mb_data_i(mb_data_i), .cpu_data_o(cpu_data_o), .cpu_data_oe_o(cpu_data_oe_o),
    .mb_data_o(mb_data_o), .mb_data_oe_o(mb_data_oe_o), .bank_o(bank_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    emu_i = v.emu; phi1_i = v.phi1; phi2_i = v.phi2; rw_i = v.rw;
    addr_i = v.addr; ind_cyc_i = v.ind; cpu_data_i = v.cpu_d; mb_data_i = v.mb_d;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk("R9 reset bank", bank_o, 4'hF);
    chk("R9 reset cpu oe", cpu_data_oe_o, 0);
    chk("R9 reset mb oe", mb_data_oe_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i) apply(VECS[i]);
      @(posedge clk_i) #1;
      chk({tag(i), " bank"}, bank_o, VECS[i].exp_bank);
      chk({tag(i), " cpu oe"}, cpu_data_oe_o, VECS[i].exp_coe);
      chk({tag(i), " mb oe"}, mb_data_oe_o, VECS[i].exp_moe);
      if (VECS[i].exp_coe) chk({tag(i), " cpu data"}, cpu_data_o, VECS[i].exp_data);
      if (VECS[i].exp_moe) chk({tag(i), " mb data"}, mb_data_o, VECS[i].exp_data);
    end

    // R2: indirect register shown only while phi2 is high
    @(negedge clk_i) apply('{1'b1,1'b0,1'b1,1'b1,16'h4000,1'b1,8'h00,8'h00,4'h0,1'b0,1'b0,8'h00});
    @(posedge clk_i) #1 chk("R2 ind in phase2", bank_o, 4'h7);
    @(negedge clk_i) phi2_i = 1'b0;
    #1 chk("R1 ind flag without phase2", bank_o, 4'h3);

    // R9: reset mid-run returns registers to bank 15
    @(negedge clk_i) rst_ni = 1'b0;
    #1 chk("R9 async reset bank", bank_o, 4'hF);
    @(negedge clk_i) rst_ni = 1'b1;
    ind_cyc_i = 1'b1; phi2_i = 1'b1;
    @(posedge clk_i) #1 chk("R9 ind after reset", bank_o, 4'hF);
    emu_i = 1'b0; phi2_i = 1'b0;
    #1 chk("R9 latch after reset", bank_o, 4'hF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule